// File: doc/BRIEF.md
# Readless Register Read Responder

This block lets a host learn the contents of a device register without a read that crosses the bus and waits for data. The host posts one request word. That word names a register offset and carries a request tag. The engine looks the offset up in the device register file. It then writes a short response record into host memory at an address the host has programmed. The host polls that memory and treats the read as finished once the tag in the record matches the tag it sent. It increments the tag for every read.

Every record is written as two memory-write beats. The value word goes out first. The tag word, which holds the echoed tag and offset, follows it. As a result, a host that sees a matching tag always finds a fresh value next to it. Requests that arrive while a record is still going out wait in a small in-order queue. None is ever lost. When the queue is full, the block pushes back on the host write port.

Top module: `rdless_resp_top`

## Requirements
- R1: Host writes select a register by word index on `hw_addr`: 0 is the request register, 1 is the low half of the response address and 2 is the high half. In a request word, bits [15:0] hold the register offset and bits [31:16] hold the request tag.
- R2: Each accepted request produces exactly two memory writes. The first puts the value word at base+4. The second puts the tag word at base+0, with the tag in bits [31:16] and the echoed offset in bits [15:0].
- R3: The value word equals `rf_rdata` when the register file reports the offset as mapped (`rf_hit` = 1). Otherwise it is 0xFFFFFFFF.
- R4: The response base is {high, low}, taken from the address registers when a response begins. Address writes made during a response only affect later responses.
- R5: Reset clears both halves of the response address to zero. A request served after reset therefore writes to addresses 0x4 and 0x0.
- R6: Requests that arrive while a response is in progress are queued, up to PEND_DEPTH of them, and served in arrival order. `hw_ready` drops only while the queue is full, and no request is dropped.
- R7: While `mw_valid` is high and `mw_ready` is low, `mw_valid` stays high and `mw_addr` and `mw_data` hold steady.
- R8: After reset, `mw_valid` is low and `hw_ready` is high.
- R9: A host write to any other word index changes neither address half and starts no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_valid | input | 1 | Host register write strobe |
| hw_ready | output | 1 | Host write accepted this cycle when high |
| hw_addr | input | HADDR_W | Host register word index |
| hw_data | input | 32 | Host write data |
| rf_addr | output | 16 | Register-file lookup offset |
| rf_rdata | input | 32 | Register-file data for `rf_addr` |
| rf_hit | input | 1 | `rf_addr` maps to a register |
| mw_valid | output | 1 | Memory write beat valid |
| mw_ready | input | 1 | Memory write beat taken |
| mw_addr | output | 64 | Memory write byte address |
| mw_data | output | 32 | Memory write data |

## Verification
The bench builds the block with its defaults, PEND_DEPTH = 2 and HADDR_W = 2. With a queue only two entries deep, three requests posted while the memory side is stalled fill it. That lets the bench reach back-pressure on the host port and then drain the queue in order. The two-bit index leaves word 3 free, which exercises the path for ignored writes. The register-file model maps only aligned offsets below 0x40, so both the mapped and unmapped cases of the value word appear.

// File: rtl/rdless_pkg.sv
package rdless_pkg;

    parameter int OFS_W  = 16;
    parameter int ID_W   = 16;
    parameter int DATA_W = OFS_W + ID_W;
    parameter int MADDR_W = 64;
    parameter int HALF_W  = MADDR_W / 2;

    // host register word indices
    parameter int REG_REQ  = 0;
    parameter int REG_ALO  = 1;
    parameter int REG_AHI  = 2;

    // byte offsets of the record words relative to the base
    parameter logic [MADDR_W-1:0] VAL_OFS = 64'd4;
    parameter logic [MADDR_W-1:0] TAG_OFS = 64'd0;

    parameter logic [DATA_W-1:0] NO_REG_VAL = '1;

    typedef struct packed {
        logic [ID_W-1:0]  tag;
        logic [OFS_W-1:0] ofs;
    } req_t;

    typedef enum logic [1:0] {
        S_IDLE,
        S_LOOK,
        S_VAL,
        S_TAG
    } seq_state_t;

    function automatic req_t unpack_req(input logic [DATA_W-1:0] w);
        req_t r;
        r.ofs = w[OFS_W-1:0];
        r.tag = w[OFS_W +: ID_W];
        return r;
    endfunction

    function automatic logic [DATA_W-1:0] pack_tag(input req_t r);
        return {r.tag, r.ofs};
    endfunction

endpackage

// File: rtl/rdless_hostif.sv
module rdless_hostif
    import rdless_pkg::*;
#(
    parameter int PEND_DEPTH = 2,
    parameter int HADDR_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_valid,
    output logic                hw_ready,
    input  logic [HADDR_W-1:0]  hw_addr,
    input  logic [DATA_W-1:0]   hw_data,
    output logic                req_valid,
    output req_t                req_head,
    input  logic                req_pop,
    output logic [MADDR_W-1:0]  base_addr
);

    localparam int CNT_W = $clog2(PEND_DEPTH + 1);
    localparam int PTR_W = (PEND_DEPTH > 1) ? $clog2(PEND_DEPTH) : 1;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(PEND_DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(PEND_DEPTH - 1);

    req_t              slot_q [PEND_DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] alo_q, ahi_q;

    logic full, accept, push, wr_lo, wr_hi;

    assign full     = (cnt_q == FULL_CNT);
    assign hw_ready = !full;
    assign accept   = hw_valid && hw_ready;
    assign push     = accept && (hw_addr == HADDR_W'(REG_REQ));
    assign wr_lo    = accept && (hw_addr == HADDR_W'(REG_ALO));
    assign wr_hi    = accept && (hw_addr == HADDR_W'(REG_AHI));

    assign req_valid = (cnt_q != '0);
    assign req_head  = slot_q[rd_ptr_q];
    assign base_addr = {ahi_q, alo_q};

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            alo_q <= '0;
            ahi_q <= '0;
        end else begin
            if (wr_lo) alo_q <= hw_data[HALF_W-1:0];
            if (wr_hi) ahi_q <= hw_data[HALF_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            cnt_q    <= '0;
        end else begin
            if (push) wr_ptr_q <= nxt(wr_ptr_q);
            if (req_pop) rd_ptr_q <= nxt(rd_ptr_q);
            case ({push, req_pop})
                2'b10:   cnt_q <= cnt_q + CNT_W'(1);
                2'b01:   cnt_q <= cnt_q - CNT_W'(1);
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    generate
        for (genvar i = 0; i < PEND_DEPTH; i++) begin : g_slot
            always_ff @(posedge clk) begin
                if (push && wr_ptr_q == PTR_W'(i))
                    slot_q[i] <= unpack_req(hw_data);
            end
        end
    endgenerate

    // R5: the response address comes out of reset at zero
    p_addr_clear_r5: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> base_addr == '0);

    // R6: the host port can only reopen after the sequencer took an entry
    p_ready_reopen_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(hw_ready) |-> $past(req_pop));

endmodule

// File: rtl/rdless_wrseq.sv
module rdless_wrseq
    import rdless_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                req_valid,
    input  req_t                req_head,
    output logic                req_pop,
    input  logic [MADDR_W-1:0]  base_addr,
    output logic [OFS_W-1:0]    rf_addr,
    input  logic [DATA_W-1:0]   rf_rdata,
    input  logic                rf_hit,
    output logic                mw_valid,
    input  logic                mw_ready,
    output logic [MADDR_W-1:0]  mw_addr,
    output logic [DATA_W-1:0]   mw_data
);

    seq_state_t         state_q;
    req_t               cur_q;
    logic [MADDR_W-1:0] base_q;
    logic [DATA_W-1:0]  val_q;

    assign req_pop = (state_q == S_IDLE) && req_valid;
    assign rf_addr = cur_q.ofs;

    always_comb begin
        mw_valid = 1'b0;
        mw_addr  = base_q + TAG_OFS;
        mw_data  = pack_tag(cur_q);
        case (state_q)
            S_VAL: begin
                mw_valid = 1'b1;
                mw_addr  = base_q + VAL_OFS;
                mw_data  = val_q;
            end
            S_TAG: mw_valid = 1'b1;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            cur_q   <= '0;
            base_q  <= '0;
            val_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (req_valid) begin
                    cur_q   <= req_head;
                    base_q  <= base_addr;
                    state_q <= S_LOOK;
                end
                S_LOOK: begin
                    val_q   <= rf_hit ? rf_rdata : NO_REG_VAL;
                    state_q <= S_VAL;
                end
                S_VAL: if (mw_ready) state_q <= S_TAG;
                S_TAG: if (mw_ready) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // R7: a stalled beat keeps its payload
    p_beat_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && !mw_ready) |=> (mw_valid && $stable(mw_addr) && $stable(mw_data)));

    // R2: the value beat is immediately followed by the tag beat of the same record
    p_tag_after_value_r2: assert property (@(posedge clk) disable iff (rst)
        (mw_valid && mw_ready && mw_addr == base_q + VAL_OFS)
        |=> (mw_valid && mw_addr == base_q + TAG_OFS && mw_data[OFS_W-1:0] == rf_addr));

    // R3: an unmapped offset yields the all-ones value
    p_unmapped_r3: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_LOOK && !rf_hit) |=> (mw_valid && mw_data == NO_REG_VAL));

    // R8: nothing is written in the cycle after reset
    p_quiet_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !mw_valid);

endmodule

// File: rtl/rdless_resp_top.sv
module rdless_resp_top
    import rdless_pkg::*;
#(
    parameter int PEND_DEPTH = 2,
    parameter int HADDR_W    = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                hw_valid,
    output logic                hw_ready,
    input  logic [HADDR_W-1:0]  hw_addr,
    input  logic [31:0]         hw_data,
    output logic [15:0]         rf_addr,
    input  logic [31:0]         rf_rdata,
    input  logic                rf_hit,
    output logic                mw_valid,
    input  logic                mw_ready,
    output logic [63:0]         mw_addr,
    output logic [31:0]         mw_data
);

    logic               req_valid, req_pop;
    req_t               req_head;
    logic [MADDR_W-1:0] base_addr;

    rdless_hostif #(
        .PEND_DEPTH (PEND_DEPTH),
        .HADDR_W    (HADDR_W)
    ) u_hostif (
        .clk       (clk),
        .rst       (rst),
        .hw_valid  (hw_valid),
        .hw_ready  (hw_ready),
        .hw_addr   (hw_addr),
        .hw_data   (hw_data),
        .req_valid (req_valid),
        .req_head  (req_head),
        .req_pop   (req_pop),
        .base_addr (base_addr)
    );

    rdless_wrseq u_wrseq (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_head  (req_head),
        .req_pop   (req_pop),
        .base_addr (base_addr),
        .rf_addr   (rf_addr),
        .rf_rdata  (rf_rdata),
        .rf_hit    (rf_hit),
        .mw_valid  (mw_valid),
        .mw_ready  (mw_ready),
        .mw_addr   (mw_addr),
        .mw_data   (mw_data)
    );

endmodule

// File: tb/tb_rdless_resp_top.sv
module tb_rdless_resp_top;

    localparam int HADDR_W = 2;

    logic        clk = 1'b0;
    logic        rst;
    logic        hw_valid;
    logic        hw_ready;
    logic [HADDR_W-1:0] hw_addr;
    logic [31:0] hw_data;
    logic [15:0] rf_addr;
    logic [31:0] rf_rdata;
    logic        rf_hit;
    logic        mw_valid;
    logic        mw_ready;
    logic [63:0] mw_addr;
    logic [31:0] mw_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [63:0] log_addr [0:255];
    logic [31:0] log_data [0:255];
    int wr_count = 0;

    always #10 clk = ~clk;

    rdless_resp_top #(.PEND_DEPTH(2), .HADDR_W(HADDR_W)) dut (
        .clk(clk), .rst(rst),
        .hw_valid(hw_valid), .hw_ready(hw_ready), .hw_addr(hw_addr), .hw_data(hw_data),
        .rf_addr(rf_addr), .rf_rdata(rf_rdata), .rf_hit(rf_hit),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
    );

    // register file model: aligned offsets below 0x40 are mapped
    assign rf_hit   = (rf_addr < 16'h0040) && (rf_addr[1:0] == 2'b00);
    assign rf_rdata = rf_hit ? (32'hC0DE_0000 | {16'h0, rf_addr}) : (32'h1234_0000 | {16'h0, rf_addr});

    function automatic logic [31:0] exp_val(input logic [15:0] ofs);
        if (ofs < 16'h0040 && ofs[1:0] == 2'b00) return 32'hC0DE_0000 | {16'h0, ofs};
        return 32'hFFFF_FFFF;
    endfunction

    always @(posedge clk) begin
        if (!rst && mw_valid && mw_ready && wr_count < 256) begin
            log_addr[wr_count] <= mw_addr;
            log_data[wr_count] <= mw_data;
            wr_count <= wr_count + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [HADDR_W-1:0] a, input logic [31:0] d);
        int guard = 0;
        @(negedge clk);
        hw_valid = 1'b1; hw_addr = a; hw_data = d;
        while (!hw_ready && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        hw_valid = 1'b0;
    endtask

    task automatic wait_writes(input int n);
        int guard = 0;
        while (wr_count < n && guard < 500) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
    endtask

    task automatic check_rec(input string req, input int n, input logic [63:0] base,
                             input logic [15:0] tag, input logic [15:0] ofs);
        chk({req, " value addr"}, log_addr[n], base + 64'd4);
        chk({req, " value data"}, {32'h0, log_data[n]}, {32'h0, exp_val(ofs)});
        chk({req, " tag addr"}, log_addr[n+1], base);
        chk({req, " tag data"}, {32'h0, log_data[n+1]}, {32'h0, tag, ofs});
    endtask

    task automatic set_base(input logic [63:0] b);
        hwrite(2'd1, b[31:0]);
        hwrite(2'd2, b[63:32]);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // R8
    task automatic t_reset_state();
        chk("R8 mw_valid after reset", {63'h0, mw_valid}, 64'h0);
        chk("R8 hw_ready after reset", {63'h0, hw_ready}, 64'h1);
    endtask

    // R1 R2 R3
    task automatic t_basic();
        logic [63:0] b = 64'h0000_0012_3456_7000;
        logic [15:0] ofs_list [4] = '{16'h0000, 16'h003C, 16'h0006, 16'h0800};
        set_base(b);
        for (int i = 0; i < 4; i++) begin
            int n0 = wr_count;
            hwrite(2'd0, {16'(16'h0100 + i), ofs_list[i]});
            wait_writes(n0 + 2);
            chk("R2 two writes per request", 64'(wr_count - n0), 64'd2);
            check_rec(i < 2 ? "R1 R2 mapped" : "R3 unmapped", n0, b, 16'(16'h0100 + i), ofs_list[i]);
        end
    endtask

    // R7
    task automatic t_stall();
        int n0 = wr_count;
        logic [63:0] a0;
        logic [31:0] d0;
        int guard = 0;
        mw_ready = 1'b0;
        hwrite(2'd0, {16'h0200, 16'h0010});
        while (!mw_valid && guard < 100) begin @(negedge clk); guard++; end
        a0 = mw_addr; d0 = mw_data;
        repeat (5) @(negedge clk);
        chk("R7 valid held", {63'h0, mw_valid}, 64'h1);
        chk("R7 addr held", mw_addr, a0);
        chk("R7 data held", {32'h0, mw_data}, {32'h0, d0});
        mw_ready = 1'b1;
        wait_writes(n0 + 2);
        check_rec("R7 record after stall", n0, 64'h0000_0012_3456_7000, 16'h0200, 16'h0010);
    endtask

    // R6
    task automatic t_queue();
        int n0 = wr_count;
        logic [63:0] b = 64'h0000_0012_3456_7000;
        mw_ready = 1'b0;
        hwrite(2'd0, {16'h0300, 16'h0004});
        hwrite(2'd0, {16'h0301, 16'h0008});
        hwrite(2'd0, {16'h0302, 16'h000C});
        repeat (3) @(negedge clk);
        chk("R6 ready low when queue full", {63'h0, hw_ready}, 64'h0);
        fork
            hwrite(2'd0, {16'h0303, 16'h0020});
            begin repeat (4) @(negedge clk); mw_ready = 1'b1; end
        join
        wait_writes(n0 + 8);
        chk("R6 all requests served", 64'(wr_count - n0), 64'd8);
        check_rec("R6 order 0", n0,     b, 16'h0300, 16'h0004);
        check_rec("R6 order 1", n0 + 2, b, 16'h0301, 16'h0008);
        check_rec("R6 order 2", n0 + 4, b, 16'h0302, 16'h000C);
        check_rec("R6 order 3", n0 + 6, b, 16'h0303, 16'h0020);
    endtask

    // R4
    task automatic t_capture();
        int n0 = wr_count;
        logic [63:0] a = 64'h0000_00AA_0000_1000;
        logic [63:0] b = 64'h0000_00BB_0000_2000;
        int guard = 0;
        set_base(a);
        mw_ready = 1'b0;
        hwrite(2'd0, {16'h0400, 16'h0014});
        while (!mw_valid && guard < 100) begin @(negedge clk); guard++; end
        set_base(b);
        mw_ready = 1'b1;
        wait_writes(n0 + 2);
        check_rec("R4 old base kept", n0, a, 16'h0400, 16'h0014);
        hwrite(2'd0, {16'h0401, 16'h0018});
        wait_writes(n0 + 4);
        check_rec("R4 new base used", n0 + 2, b, 16'h0401, 16'h0018);
    endtask

    // R9
    task automatic t_ignored();
        int n0 = wr_count;
        hwrite(2'd3, 32'hDEAD_BEEF);
        repeat (6) @(negedge clk);
        chk("R9 no response from unused index", 64'(wr_count - n0), 64'd0);
        hwrite(2'd0, {16'h0500, 16'h0024});
        wait_writes(n0 + 2);
        check_rec("R9 base unchanged", n0, 64'h0000_00BB_0000_2000, 16'h0500, 16'h0024);
    endtask

    // R5
    task automatic t_reset_clears();
        int n0;
        do_reset();
        n0 = wr_count;
        hwrite(2'd0, {16'h0600, 16'h0028});
        wait_writes(n0 + 2);
        check_rec("R5 base zero after reset", n0, 64'h0, 16'h0600, 16'h0028);
    endtask

    initial begin
        rst = 1'b1; hw_valid = 1'b0; hw_addr = '0; hw_data = '0; mw_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_stall();
        t_queue();
        t_capture();
        t_ignored();
        t_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule